// File: doc/BRIEF.md
# Power Management Function Decoder

This block is the register slice of a power-management function. It carries the configuration state that places two relocatable host I/O windows (a 128-byte power-management event window and a 16-byte SMBus window), decodes every host I/O address into a hit signal for each window, and keeps a small PM1 event status/enable pair that drives a level-sensitive system control interrupt (SCI).

Configuration software writes dword-addressed registers with per-byte enables. Base registers drop the address bits below their window size and force bit 0 high, so a read never returns a malformed base. Host code reaches the PM1 status and enable words through the PM window itself. Hardware event sources enter as single-cycle pulses. The SMBus controller, the timer counter and sleep sequencing sit outside this block.

Top module: `pm_func_decoder`

## Requirements
- R1: The PM base register (config dword 0x48) stores address bits [15:7] only; a read returns those bits in place, bit 0 as 1 and every other bit as 0.
- R2: The SMBus base register (config dword 0x90) stores address bits [15:4] only; a read returns those bits in place, bit 0 as 1 and every other bit as 0.
- R3: pmHit is 1 exactly when bit 7 of config byte 0x41 is set and ioAddr[15:7] equals the stored PM base; clearing that bit stops all PM hits from the next cycle.
- R4: Config byte 0xd2 keeps only its low 4 bits (upper bits read 0); its bit 0 enables the SMBus window, and smbHit is 1 exactly when it is set and ioAddr[15:4] equals the stored SMBus base.
- R5: After reset both base registers read 0x00000001, both windows are disabled, PM1 status and enable read 0, and the interrupt-pin byte (config byte 0x3d) reads 0x01.
- R6: A config write changes only the bytes whose byte enable is set; a write touching only non-stored bytes of a base register leaves its read value unchanged with the forced bits intact.
- R7: evtPulse[0] (timer overflow), [1] (global lock), [2] (power button) and [3] (RTC alarm) set PM1 status bits 0, 5, 8 and 10; the status word is at PM window offset 0 and the enable word, using the same bit positions, at offset 2. Other bits read 0.
- R8: Writing the status word clears each status bit written as 1 and leaves bits written as 0; a pulse in the same cycle as a clear of the same bit leaves it set.
- R9: sciOut is 1 while any of the four sources is both pending and enabled, and falls in the cycle after the write that clears the last such bit.
- R10: While the interrupt-pin byte is zero, sciOut stays 0 whatever the status and enable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config write strobe |
| cfgAddr | input | 8 | Config byte address; bits [7:2] select the dword |
| cfgByteEn | input | 4 | Config write byte enables |
| cfgWrData | input | 32 | Config write data |
| cfgRdData | output | 32 | Config read data for the addressed dword |
| ioAddr | input | 16 | Host I/O address |
| ioWrEn | input | 1 | Host I/O word write strobe |
| ioWrData | input | 16 | Host I/O write data |
| ioRdData | output | 16 | Host I/O read data for the PM1 words |
| evtPulse | input | 4 | Event pulses: timer, global lock, power button, RTC alarm |
| pmHit | output | 1 | Address falls in the enabled PM window |
| smbHit | output | 1 | Address falls in the enabled SMBus window |
| sciOut | output | 1 | Level system control interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit host address, a 128-byte PM window and a 16-byte SMBus window. With those widths every compare bit is reachable, so address probes sit one below, at, inside and one past the edge of each window, and one differs only in the top bit. The interrupt-pin reset value of 1 lets SCI be exercised straight after reset, before the pin byte is rewritten to zero.

// File: rtl/pmfd_pkg.sv
package pmfd_pkg;

  localparam int EVT_N = 4;

  // PM1 bit position for each event index: timer, global lock, power button, RTC
  localparam int STS_POS [EVT_N] = '{0, 5, 8, 10};

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PIN,
    SEL_PMCTL,
    SEL_PMBASE,
    SEL_SMBBASE,
    SEL_SMBCTL
  } cfgSel_t;

  typedef struct packed {
    logic wrPin;
    logic wrPmCtl;
    logic wrPmBase;
    logic wrSmbBase;
    logic wrSmbCtl;
    logic wrSts;
    logic wrEnable;
    logic rdSts;
    logic rdEnable;
  } pmStrobe_t;

  function automatic logic [15:0] spreadEvt(input logic [EVT_N-1:0] v);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < EVT_N; i++) r[STS_POS[i]] = v[i];
    return r;
  endfunction

  function automatic logic [EVT_N-1:0] gatherEvt(input logic [15:0] w);
    logic [EVT_N-1:0] r;
    for (int i = 0; i < EVT_N; i++) r[i] = w[STS_POS[i]];
    return r;
  endfunction

endpackage

// File: rtl/pmfd_ctrl.sv
module pmfd_ctrl
  import pmfd_pkg::*;
#(
  parameter int CFG_AW       = 8,
  parameter int IO_AW        = 16,
  parameter int PM_WIN_LOG2  = 7,
  parameter int SMB_WIN_LOG2 = 4,
  parameter logic [CFG_AW-1:0] PIN_OFF     = 8'h3C,
  parameter logic [CFG_AW-1:0] PMCTL_OFF   = 8'h40,
  parameter logic [CFG_AW-1:0] PMBASE_OFF  = 8'h48,
  parameter logic [CFG_AW-1:0] SMBBASE_OFF = 8'h90,
  parameter logic [CFG_AW-1:0] SMBCTL_OFF  = 8'hD0,
  parameter int STS_OFF = 0,
  parameter int EN_OFF  = 2
) (
  input  logic                          cfgWrEn,
  input  logic [CFG_AW-1:0]             cfgAddr,
  input  logic [IO_AW-1:0]              ioAddr,
  input  logic                          ioWrEn,
  input  logic                          pmEn,
  input  logic                          smbEn,
  input  logic [IO_AW-1:PM_WIN_LOG2]    pmBase,
  input  logic [IO_AW-1:SMB_WIN_LOG2]   smbBase,
  output pmStrobe_t                     strobe,
  output cfgSel_t                       cfgSel,
  output logic                          pmHit,
  output logic                          smbHit
);

  localparam int DW_HI = CFG_AW - 1;
  localparam logic [PM_WIN_LOG2-1:0] STS_O = PM_WIN_LOG2'(STS_OFF);
  localparam logic [PM_WIN_LOG2-1:0] EN_O  = PM_WIN_LOG2'(EN_OFF);

  logic [DW_HI:2] dw;
  logic [PM_WIN_LOG2-1:0] pmOff;

  assign dw    = cfgAddr[DW_HI:2];
  assign pmOff = ioAddr[PM_WIN_LOG2-1:0];

  always_comb begin
    cfgSel = SEL_NONE;
    if (dw == PIN_OFF[DW_HI:2])          cfgSel = SEL_PIN;
    else if (dw == PMCTL_OFF[DW_HI:2])   cfgSel = SEL_PMCTL;
    else if (dw == PMBASE_OFF[DW_HI:2])  cfgSel = SEL_PMBASE;
    else if (dw == SMBBASE_OFF[DW_HI:2]) cfgSel = SEL_SMBBASE;
    else if (dw == SMBCTL_OFF[DW_HI:2])  cfgSel = SEL_SMBCTL;
  end

  assign pmHit  = pmEn  && (ioAddr[IO_AW-1:PM_WIN_LOG2]  == pmBase);
  assign smbHit = smbEn && (ioAddr[IO_AW-1:SMB_WIN_LOG2] == smbBase);

  always_comb begin
    strobe           = '0;
    strobe.wrPin     = cfgWrEn && (cfgSel == SEL_PIN);
    strobe.wrPmCtl   = cfgWrEn && (cfgSel == SEL_PMCTL);
    strobe.wrPmBase  = cfgWrEn && (cfgSel == SEL_PMBASE);
    strobe.wrSmbBase = cfgWrEn && (cfgSel == SEL_SMBBASE);
    strobe.wrSmbCtl  = cfgWrEn && (cfgSel == SEL_SMBCTL);
    strobe.rdSts     = pmHit && (pmOff == STS_O);
    strobe.rdEnable  = pmHit && (pmOff == EN_O);
    strobe.wrSts     = ioWrEn && strobe.rdSts;
    strobe.wrEnable  = ioWrEn && strobe.rdEnable;
  end

endmodule

// File: rtl/pmfd_dpath.sv
module pmfd_dpath
  import pmfd_pkg::*;
#(
  parameter int IO_AW        = 16,
  parameter int PM_WIN_LOG2  = 7,
  parameter int SMB_WIN_LOG2 = 4,
  parameter logic [7:0] PIN_RST = 8'h01
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pmStrobe_t                    strobe,
  input  cfgSel_t                      cfgSel,
  input  logic [3:0]                   cfgByteEn,
  input  logic [31:0]                  cfgWrData,
  input  logic [15:0]                  ioWrData,
  input  logic [EVT_N-1:0]             evtPulse,
  output logic [31:0]                  cfgRdData,
  output logic [15:0]                  ioRdData,
  output logic                         pmEn,
  output logic                         smbEn,
  output logic [IO_AW-1:PM_WIN_LOG2]   pmBase,
  output logic [IO_AW-1:SMB_WIN_LOG2]  smbBase,
  output logic                         sciOut
);

  logic [7:0]        pinQ;
  logic [3:0]        smbCtlQ;
  logic [EVT_N-1:0]  stsQ;
  logic [EVT_N-1:0]  enQ;
  logic [EVT_N-1:0]  clrMask;

  assign smbEn   = smbCtlQ[0];
  assign clrMask = strobe.wrSts ? gatherEvt(ioWrData) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinQ    <= PIN_RST;
      pmEn    <= 1'b0;
      smbCtlQ <= '0;
      pmBase  <= '0;
      smbBase <= '0;
      stsQ    <= '0;
      enQ     <= '0;
    end else begin
      if (strobe.wrPin && cfgByteEn[1]) pinQ <= cfgWrData[15:8];
      if (strobe.wrPmCtl && cfgByteEn[1]) pmEn <= cfgWrData[15];
      if (strobe.wrSmbCtl && cfgByteEn[2]) smbCtlQ <= cfgWrData[19:16];
      if (strobe.wrPmBase) begin
        for (int i = PM_WIN_LOG2; i < IO_AW; i++)
          if (cfgByteEn[i/8]) pmBase[i] <= cfgWrData[i];
      end
      if (strobe.wrSmbBase) begin
        for (int i = SMB_WIN_LOG2; i < IO_AW; i++)
          if (cfgByteEn[i/8]) smbBase[i] <= cfgWrData[i];
      end
      stsQ <= (stsQ & ~clrMask) | evtPulse;
      if (strobe.wrEnable) enQ <= gatherEvt(ioWrData);
    end
  end

  always_comb begin
    cfgRdData = '0;
    unique case (cfgSel)
      SEL_PIN:     cfgRdData[15:8] = pinQ;
      SEL_PMCTL:   cfgRdData[15] = pmEn;
      SEL_PMBASE:  begin
        cfgRdData[IO_AW-1:PM_WIN_LOG2] = pmBase;
        cfgRdData[0] = 1'b1;
      end
      SEL_SMBBASE: begin
        cfgRdData[IO_AW-1:SMB_WIN_LOG2] = smbBase;
        cfgRdData[0] = 1'b1;
      end
      SEL_SMBCTL:  cfgRdData[19:16] = smbCtlQ;
      default:     cfgRdData = '0;
    endcase
  end

  always_comb begin
    ioRdData = '0;
    if (strobe.rdSts)         ioRdData = spreadEvt(stsQ);
    else if (strobe.rdEnable) ioRdData = spreadEvt(enQ);
  end

  assign sciOut = (pinQ != 8'h00) && |(stsQ & enQ);

endmodule

// File: rtl/pm_func_decoder.sv
module pm_func_decoder
  import pmfd_pkg::*;
#(
  parameter int CFG_AW       = 8,
  parameter int IO_AW        = 16,
  parameter int PM_WIN_LOG2  = 7,
  parameter int SMB_WIN_LOG2 = 4,
  parameter logic [7:0] PIN_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic              ioWrEn,
  input  logic [15:0]       ioWrData,
  output logic [15:0]       ioRdData,
  input  logic [EVT_N-1:0]  evtPulse,
  output logic              pmHit,
  output logic              smbHit,
  output logic              sciOut
);

  pmStrobe_t                    strobe;
  cfgSel_t                      cfgSel;
  logic                         pmEn;
  logic                         smbEn;
  logic [IO_AW-1:PM_WIN_LOG2]   pmBase;
  logic [IO_AW-1:SMB_WIN_LOG2]  smbBase;

  pmfd_ctrl #(
    .CFG_AW(CFG_AW), .IO_AW(IO_AW),
    .PM_WIN_LOG2(PM_WIN_LOG2), .SMB_WIN_LOG2(SMB_WIN_LOG2)
  ) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .pmEn(pmEn), .smbEn(smbEn), .pmBase(pmBase), .smbBase(smbBase),
    .strobe(strobe), .cfgSel(cfgSel), .pmHit(pmHit), .smbHit(smbHit)
  );

  pmfd_dpath #(
    .IO_AW(IO_AW), .PM_WIN_LOG2(PM_WIN_LOG2),
    .SMB_WIN_LOG2(SMB_WIN_LOG2), .PIN_RST(PIN_RST)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgSel(cfgSel),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .ioWrData(ioWrData),
    .evtPulse(evtPulse), .cfgRdData(cfgRdData), .ioRdData(ioRdData),
    .pmEn(pmEn), .smbEn(smbEn), .pmBase(pmBase), .smbBase(smbBase),
    .sciOut(sciOut)
  );

endmodule

// File: rtl/pm_func_decoder_chk.sv
module pm_func_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [7:0]  cfgAddr,
  input logic [3:0]  cfgByteEn,
  input logic [31:0] cfgWrData,
  input logic [31:0] cfgRdData,
  input logic        ioWrEn,
  input logic [3:0]  evtPulse,
  input logic        pmHit,
  input logic        sciOut
);

  // R1
  pm_base_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr[7:2] == 6'h12) |-> (cfgRdData[6:0] == 7'h01 && cfgRdData[31:16] == 16'h0));

  // R2
  smb_base_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr[7:2] == 6'h24) |-> (cfgRdData[3:0] == 4'h1 && cfgRdData[31:16] == 16'h0));

  // R3
  pm_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr[7:2] == 6'h10 && cfgByteEn[1] && !cfgWrData[15]) |=> !pmHit);

  // R10
  pin_zero_sci_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr[7:2] == 6'h0F && cfgByteEn[1] && cfgWrData[15:8] == 8'h00) |=> !sciOut);

  // R9
  sci_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sciOut) |-> $past(|evtPulse || cfgWrEn || ioWrEn));

endmodule

bind pm_func_decoder pm_func_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
  .ioWrEn(ioWrEn), .evtPulse(evtPulse), .pmHit(pmHit), .sciOut(sciOut)
);

// File: tb/pm_func_decoder_bench.sv
module pm_func_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [15:0] ioAddr = '0;
  logic        ioWrEn = 1'b0;
  logic [15:0] ioWrData = '0;
  logic [15:0] ioRdData;
  logic [3:0]  evtPulse = '0;
  logic        pmHit, smbHit, sciOut;

  int errors = 0;
  int total  = 0;

  always #10 clk = ~clk;

  pm_func_decoder u_pm_func_decoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .evtPulse(evtPulse), .pmHit(pmHit), .smbHit(smbHit), .sciOut(sciOut)
  );

  // {ioAddr, pmHit expected, smbHit expected}; PM base 0x4C00, SMBus base 0xA0B0
  localparam logic [17:0] VEC [10] = '{
    {16'h4C00, 1'b1, 1'b0}, {16'h4C7F, 1'b1, 1'b0}, {16'h4C80, 1'b0, 1'b0},
    {16'h4BFF, 1'b0, 1'b0}, {16'hA0B0, 1'b0, 1'b1}, {16'hA0BF, 1'b0, 1'b1},
    {16'hA0C0, 1'b0, 1'b0}, {16'hA0AF, 1'b0, 1'b0}, {16'h0000, 1'b0, 1'b0},
    {16'hCC00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0;
  endtask

  task automatic cfgRd(input string req, input logic [7:0] a, input logic [31:0] exp);
    cfgAddr = a; #1;
    chk(req, cfgRdData, exp);
  endtask

  task automatic ioWr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRd(input string req, input logic [15:0] a, input logic [15:0] exp);
    ioAddr = a; #1;
    chk(req, {16'h0, ioRdData}, {16'h0, exp});
  endtask

  task automatic pulse(input logic [3:0] p);
    @(negedge clk);
    evtPulse = p;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R5 reset state
    cfgRd("R5 pm base", 8'h48, 32'h0000_0001);
    cfgRd("R5 smb base", 8'h90, 32'h0000_0001);
    cfgRd("R5 pin byte", 8'h3C, 32'h0000_0100);
    ioAddr = 16'h0000; #1;
    chk("R5 pm disabled", {31'h0, pmHit}, 32'h0);
    chk("R5 smb disabled", {31'h0, smbHit}, 32'h0);
    chk("R5 sci low", {31'h0, sciOut}, 32'h0);

    // R1 R2 forced bits on full writes
    cfgWr(8'h48, 4'hF, 32'hDEAD_4C7F);
    cfgRd("R1 pm base masked", 8'h48, 32'h0000_4C01);
    cfgWr(8'h90, 4'hF, 32'hFFFF_A0BE);
    cfgRd("R2 smb base masked", 8'h90, 32'h0000_A0B1);

    // R4 control byte keeps low nibble
    cfgWr(8'hD0, 4'h4, 32'h00FF_0000);
    cfgRd("R4 smb ctl nibble", 8'hD0, 32'h000F_0000);
    cfgWr(8'h40, 4'h2, 32'h0000_FF00);
    cfgRd("R3 pm ctl bit7", 8'h40, 32'h0000_8000);

    // R3 R4 window decode table
    for (int i = 0; i < 10; i++) begin
      ioAddr = VEC[i][17:2]; #1;
      chk($sformatf("R3 pmHit @%h", VEC[i][17:2]), {31'h0, pmHit}, {31'h0, VEC[i][1]});
      chk($sformatf("R4 smbHit @%h", VEC[i][17:2]), {31'h0, smbHit}, {31'h0, VEC[i][0]});
    end

    // R7 R9 timer source enabled
    ioWr(16'h4C02, 16'h0001);
    ioRd("R7 enable word", 16'h4C02, 16'h0001);
    pulse(4'b0001);
    ioRd("R7 status timer", 16'h4C00, 16'h0001);
    chk("R9 sci on", {31'h0, sciOut}, 32'h1);

    // R9 pending but not enabled source; R7 mapping of all four
    pulse(4'b1110);
    ioRd("R7 status all", 16'h4C00, 16'h0521);
    // R8 writing zero clears nothing
    ioWr(16'h4C00, 16'h0000);
    ioRd("R8 zero write", 16'h4C00, 16'h0521);
    // R8 clear timer only; R9 sci falls with power button still pending
    ioWr(16'h4C00, 16'h0001);
    ioRd("R8 w1c timer", 16'h4C00, 16'h0520);
    chk("R9 sci off", {31'h0, sciOut}, 32'h0);
    ioWr(16'h4C02, 16'h0100);
    chk("R9 sci power button", {31'h0, sciOut}, 32'h1);

    // R8 set wins over clear in same cycle
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = 16'h4C00; ioWrData = 16'h0100; evtPulse = 4'b0100;
    @(negedge clk);
    ioWrEn = 1'b0; evtPulse = '0;
    ioRd("R8 set wins", 16'h4C00, 16'h0520);

    // R10 pin byte zero blocks SCI
    cfgWr(8'h3C, 4'h2, 32'h0000_0000);
    chk("R10 sci blocked", {31'h0, sciOut}, 32'h0);
    cfgWr(8'h3C, 4'h2, 32'h0000_0200);
    chk("R10 sci restored", {31'h0, sciOut}, 32'h1);

    // R6 byte-enable partial writes
    cfgWr(8'h48, 4'h2, 32'h0000_80FF);
    cfgRd("R6 pm base byte1", 8'h48, 32'h0000_8001);
    cfgWr(8'h48, 4'hC, 32'hFFFF_FFFF);
    cfgRd("R6 pm base high bytes", 8'h48, 32'h0000_8001);
    cfgWr(8'h90, 4'h1, 32'h0000_00C7);
    cfgRd("R6 smb base byte0", 8'h90, 32'h0000_A0C1);

    // R3 disable stops hits
    ioAddr = 16'h8000; #1;
    chk("R3 hit new base", {31'h0, pmHit}, 32'h1);
    cfgWr(8'h40, 4'h2, 32'h0000_0000);
    ioAddr = 16'h8000; #1;
    chk("R3 hit disabled", {31'h0, pmHit}, 32'h0);
    // R4 smb disable
    cfgWr(8'hD0, 4'h4, 32'h000E_0000);
    ioAddr = 16'hA0C0; #1;
    chk("R4 smb disabled", {31'h0, smbHit}, 32'h0);

    finishRun();
  end

endmodule